// File: doc/BRIEF.md
# Fast Ethernet Transmit PCS Encoder

This block turns a nibble-wide frame from a MAC into the three-level line code of 100 Mb/s twisted-pair Ethernet. It runs entirely on the 125 MHz symbol clock. A divide-by-five phase counter raises `nib_stb` for one cycle in five. That strobe marks the 25 MHz nibble rate at which the MAC presents `txd` and `tx_en`.

Each sampled nibble yields one 5-bit code group. A framing machine swaps the first preamble octet for the start delimiter pair. It encodes the payload nibbles through the 4B5B table and appends the end delimiter pair when the enable drops. Between frames it fills the line with idle groups. The code groups leave most significant bit first, one bit per symbol clock. Each bit is XORed with the output of a free-running 11-bit scrambler and then drives an MLT-3 level stage. The stage presents the level as a 2-bit signed code.

Top module: `fe_tx_pcs`

## Requirements
- R1: While `rst_n` is low, `line_lvl` is 0 (code 00) and `nib_stb` is low. The first code group after reset is idle, and the framing machine restarts outside any frame.
- R2: If `tx_en` is sampled high while no frame is active, the group J=11000 is sent for that nibble and K=10001 for the next one, whatever values those two nibbles hold.
- R3: If `tx_en` is sampled low during the payload, T=01101 is sent for that nibble and R=00111 for the next one. `tx_en` is ignored while R is chosen. A new frame may begin on the nibble right after R.
- R4: Each payload nibble is sent as its 4B5B code group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: While no frame is active, the idle group 11111 is sent for every nibble.
- R6: Each serial bit is XORed with a key bit k = s[10] XOR s[8] of an 11-bit register s. The register shifts every symbol clock as s ← {s[9:0], k}, which gives the polynomial x^11+x^9+1. It is loaded with the nonzero `SCR_SEED` at reset. When `SCRAMBLE_EN` is 0, the bits pass unchanged.
- R7: `line_lvl` uses the codes 00 for zero, 01 for +1 and 11 for -1, and never shows 10. A 0 bit holds the level on the next cycle. A 1 bit steps it through the cycle 0, +1, 0, -1, and the first step after reset goes to +1.
- R8: `nib_stb` is high for one cycle in every five. The first strobe comes in the fifth cycle after reset is released. `txd` and `tx_en` are sampled at the rising edge that ends a strobe cycle. The most significant bit of the chosen group enters the scrambler in the next cycle. The level it produces appears on `line_lvl` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | NIB_W | Transmit nibble from the MAC |
| tx_en | input | 1 | Frame enable from the MAC |
| nib_stb | output | 1 | Nibble strobe; inputs are taken at the edge ending this cycle |
| line_lvl | output | 2 | MLT-3 level: 00 zero, 01 plus, 11 minus |

## Verification
The bench builds two copies side by side with the default code widths and the same seed. One copy has `SCRAMBLE_EN` at 1 and the other has it at 0. The unscrambled copy exposes the raw code-group stream directly as MLT-3 transitions, so delimiter placement, 4B5B mapping and bit order can be checked without any key. The scrambled copy is descrambled with an independently stepped x^11+x^9+1 model started from the same seed. That check proves the key sequence and its alignment to the bit stream, and comparing the two lines shows the scrambler is really applied.

// File: rtl/fe_pcs_pkg.sv
package fe_pcs_pkg;

   // line level codes (2-bit signed)
   localparam logic [1:0] LVL_ZERO = 2'b00;
   localparam logic [1:0] LVL_POS  = 2'b01;
   localparam logic [1:0] LVL_NEG  = 2'b11;

   // control code groups
   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SSD2 = 2'd1,
      FR_DATA = 2'd2,
      FR_ESD2 = 2'd3
   } fr_state_e;

   function automatic logic [4:0] enc_4b5b(input logic [3:0] nib);
      logic [4:0] cg;
      case (nib)
         4'h0: cg = 5'b11110;
         4'h1: cg = 5'b01001;
         4'h2: cg = 5'b10100;
         4'h3: cg = 5'b10101;
         4'h4: cg = 5'b01010;
         4'h5: cg = 5'b01011;
         4'h6: cg = 5'b01110;
         4'h7: cg = 5'b01111;
         4'h8: cg = 5'b10010;
         4'h9: cg = 5'b10011;
         4'hA: cg = 5'b10110;
         4'hB: cg = 5'b10111;
         4'hC: cg = 5'b11010;
         4'hD: cg = 5'b11011;
         4'hE: cg = 5'b11100;
         default: cg = 5'b11101;
      endcase
      return cg;
   endfunction

endpackage

// File: rtl/fe_pcs_framer.sv
// Chooses the code group for each sampled nibble (R2, R3, R4, R5).
module fe_pcs_framer
   import fe_pcs_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int SYM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             tx_en,
   input  logic [NIB_W-1:0] txd,
   output logic [SYM_W-1:0] cg_next
);

   fr_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      cg_next = CG_IDLE;
      case (st_q)
         FR_IDLE: begin
            if (tx_en) begin
               cg_next = CG_J;       // first preamble nibble replaced
               st_d    = FR_SSD2;
            end
         end
         FR_SSD2: begin
            cg_next = CG_K;          // second preamble nibble replaced
            st_d    = FR_DATA;
         end
         FR_DATA: begin
            if (tx_en) begin
               cg_next = enc_4b5b(txd);
            end else begin
               cg_next = CG_T;
               st_d    = FR_ESD2;
            end
         end
         default: begin               // FR_ESD2, enable ignored here
            cg_next = CG_R;
            st_d    = FR_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= FR_IDLE;
      else if (stb) st_q <= st_d;
   end

endmodule

// File: rtl/fe_pcs_shifter.sv
// Nibble phase counter and MSB-first code-group shifter (R8).
module fe_pcs_shifter
   import fe_pcs_pkg::*;
#(
   parameter int SYM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] load,
   output logic             stb,
   output logic             bit_o
);

   localparam int                PH_W    = $clog2(SYM_W);
   localparam logic [PH_W-1:0]   PH_LAST = PH_W'(SYM_W - 1);

   logic [PH_W-1:0]  ph_q;
   logic [SYM_W-1:0] sh_q;

   assign stb   = (ph_q == PH_LAST);
   assign bit_o = sh_q[SYM_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
         sh_q <= CG_IDLE;
      end else if (stb) begin
         ph_q <= '0;
         sh_q <= load;
      end else begin
         ph_q <= ph_q + 1'b1;
         sh_q <= {sh_q[SYM_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/fe_pcs_scrambler.sv
// Free-running additive scrambler, or a bypass (R6).
module fe_pcs_scrambler #(
   parameter int              LFSR_W = 11,
   parameter int              TAP    = 9,
   parameter logic [LFSR_W-1:0] SEED = 11'h5A5,
   parameter bit              ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (ENABLE) begin : g_scr
         logic [LFSR_W-1:0] lfsr_q;
         logic              key;

         assign key  = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP-1];
         assign dout = din ^ key;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lfsr_q <= SEED;
            else        lfsr_q <= {lfsr_q[LFSR_W-2:0], key};
         end
      end else begin : g_bypass
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/fe_pcs_mlt3.sv
// Three-level line coder (R7).
module fe_pcs_mlt3
   import fe_pcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_i,
   output logic [1:0] lvl_o
);

   logic [1:0] lvl_q;
   logic       neg_next_q;

   assign lvl_o = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q      <= LVL_ZERO;
         neg_next_q <= 1'b0;
      end else if (bit_i) begin
         if (lvl_q == LVL_ZERO) begin
            lvl_q      <= neg_next_q ? LVL_NEG : LVL_POS;
            neg_next_q <= ~neg_next_q;
         end else begin
            lvl_q <= LVL_ZERO;
         end
      end
   end

endmodule

// File: rtl/fe_tx_pcs.sv
module fe_tx_pcs
   import fe_pcs_pkg::*;
#(
   parameter int                NIB_W       = 4,
   parameter int                SYM_W       = 5,
   parameter int                LFSR_W      = 11,
   parameter int                LFSR_TAP    = 9,
   parameter logic [LFSR_W-1:0] SCR_SEED    = 11'h5A5,
   parameter bit                SCRAMBLE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] txd,
   input  logic             tx_en,
   output logic             nib_stb,
   output logic [1:0]       line_lvl
);

   generate
      if (NIB_W != 4 || SYM_W != 5) begin : g_bad_code
         $error("fe_tx_pcs: the 4B5B code needs NIB_W=4 and SYM_W=5");
      end
      if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_W) begin : g_bad_tap
         $error("fe_tx_pcs: LFSR_TAP must lie below LFSR_W");
      end
      if (SCRAMBLE_EN && SCR_SEED == '0) begin : g_bad_seed
         $error("fe_tx_pcs: scrambler seed must be nonzero");
      end
   endgenerate

   logic [SYM_W-1:0] cg_next;
   logic             ser_bit;
   logic             scr_bit;

   fe_pcs_framer #(.NIB_W(NIB_W), .SYM_W(SYM_W)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (nib_stb),
      .tx_en   (tx_en),
      .txd     (txd),
      .cg_next (cg_next)
   );

   fe_pcs_shifter #(.SYM_W(SYM_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cg_next),
      .stb   (nib_stb),
      .bit_o (ser_bit)
   );

   fe_pcs_scrambler #(
      .LFSR_W (LFSR_W),
      .TAP    (LFSR_TAP),
      .SEED   (SCR_SEED),
      .ENABLE (SCRAMBLE_EN)
   ) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ser_bit),
      .dout  (scr_bit)
   );

   fe_pcs_mlt3 u_mlt3 (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_i (scr_bit),
      .lvl_o (line_lvl)
   );

endmodule

// File: rtl/fe_tx_pcs_chk.sv
module fe_tx_pcs_chk
   import fe_pcs_pkg::*;
#(
   parameter int SYM_W = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       nib_stb,
   input logic       ser_bit,
   input logic [1:0] line_lvl
);

   localparam int            CW   = $clog2(SYM_W) + 1;
   localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

   logic [CW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gap_q <= '0;
      else if (nib_stb) gap_q <= '0;
      else              gap_q <= gap_q + 1'b1;
   end

   // R7: the reserved level code is never driven
   p_lvl_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_lvl != 2'b10);

   // R7: a level change always passes through zero
   p_mlt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_lvl != $past(line_lvl)) |-> (line_lvl == LVL_ZERO || $past(line_lvl) == LVL_ZERO));

   // R7: a zero bit holds the level
   p_mlt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_bit |=> $stable(line_lvl));

   // R7: a one bit moves the level
   p_mlt_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ser_bit |=> !$stable(line_lvl));

   // R8: strobe comes exactly once per symbol period
   p_stb_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb |-> gap_q == LAST);

   p_stb_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q == LAST) |-> nib_stb);

endmodule

bind fe_tx_pcs fe_tx_pcs_chk #(.SYM_W(SYM_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .nib_stb  (nib_stb),
   .ser_bit  (scr_bit),
   .line_lvl (line_lvl)
);

// File: tb/fe_tx_pcs_tb.sv
module fe_tx_pcs_tb;

   localparam logic [10:0] SEED = 11'h5A5;
   localparam logic [4:0]  I_CG = 5'b11111;
   localparam logic [4:0]  J_CG = 5'b11000;
   localparam logic [4:0]  K_CG = 5'b10001;
   localparam logic [4:0]  T_CG = 5'b01101;
   localparam logic [4:0]  R_CG = 5'b00111;

   typedef struct packed {
      logic       en;
      logic [3:0] nib;
      logic [4:0] cg;
      logic [3:0] tag;   // requirement number
   } vec_t;

   // stimulus and expected code group, one entry per nibble
   localparam int NV = 40;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'h0, I_CG,     4'd5},  // R5 idle
      '{1'b1, 4'h5, J_CG,     4'd2},  // R2
      '{1'b1, 4'h5, K_CG,     4'd2},
      '{1'b1, 4'h0, 5'b11110, 4'd4},  // R4 table
      '{1'b1, 4'h1, 5'b01001, 4'd4},
      '{1'b1, 4'h2, 5'b10100, 4'd4},
      '{1'b1, 4'h3, 5'b10101, 4'd4},
      '{1'b1, 4'h4, 5'b01010, 4'd4},
      '{1'b1, 4'h5, 5'b01011, 4'd4},
      '{1'b1, 4'h6, 5'b01110, 4'd4},
      '{1'b1, 4'h7, 5'b01111, 4'd4},
      '{1'b1, 4'h8, 5'b10010, 4'd4},
      '{1'b1, 4'h9, 5'b10011, 4'd4},
      '{1'b1, 4'hA, 5'b10110, 4'd4},
      '{1'b1, 4'hB, 5'b10111, 4'd4},
      '{1'b1, 4'hC, 5'b11010, 4'd4},
      '{1'b1, 4'hD, 5'b11011, 4'd4},
      '{1'b1, 4'hE, 5'b11100, 4'd4},
      '{1'b1, 4'hF, 5'b11101, 4'd4},
      '{1'b0, 4'h0, T_CG,     4'd3},  // R3
      '{1'b0, 4'h0, R_CG,     4'd3},
      '{1'b0, 4'h0, I_CG,     4'd5},
      '{1'b1, 4'h5, J_CG,     4'd2},
      '{1'b1, 4'hD, K_CG,     4'd2},  // second octet nibble value ignored
      '{1'b0, 4'h0, T_CG,     4'd3},  // frame with no payload
      '{1'b0, 4'h0, R_CG,     4'd3},
      '{1'b1, 4'h3, J_CG,     4'd2},
      '{1'b0, 4'h0, K_CG,     4'd2},  // enable dropped inside the octet
      '{1'b0, 4'h0, T_CG,     4'd3},
      '{1'b0, 4'h0, R_CG,     4'd3},
      '{1'b1, 4'h5, J_CG,     4'd2},
      '{1'b1, 4'h5, K_CG,     4'd2},
      '{1'b1, 4'hA, 5'b10110, 4'd4},
      '{1'b0, 4'h0, T_CG,     4'd3},
      '{1'b1, 4'h7, R_CG,     4'd3},  // enable ignored during R
      '{1'b1, 4'h5, J_CG,     4'd3},  // back-to-back start
      '{1'b1, 4'h5, K_CG,     4'd2},
      '{1'b0, 4'h0, T_CG,     4'd3},
      '{1'b0, 4'h0, R_CG,     4'd3},
      '{1'b0, 4'h0, I_CG,     4'd5}
   };

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] txd   = 4'h0;
   logic       tx_en = 1'b0;
   logic       stb_s, stb_r;
   logic [1:0] lvl_s, lvl_r;

   always #10 clk = ~clk;

   fe_tx_pcs #(.SCR_SEED(SEED)) u_dut (
      .clk (clk), .rst_n (rst_n), .txd (txd), .tx_en (tx_en),
      .nib_stb (stb_s), .line_lvl (lvl_s)
   );

   fe_tx_pcs #(.SCR_SEED(SEED), .SCRAMBLE_EN(1'b0)) u_raw (
      .clk (clk), .rst_n (rst_n), .txd (txd), .tx_en (tx_en),
      .nib_stb (stb_r), .line_lvl (lvl_r)
   );

   int n_chk  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // independent key model, x^11+x^9+1 (R6)
   logic [10:0] s_m;
   always @(posedge clk) begin
      if (!rst_n) s_m <= SEED;
      else        s_m <= {s_m[9:0], s_m[10] ^ s_m[8]};
   end

   vec_t       exp_q[$];
   logic [1:0] prev_s, prev_r;
   logic [4:0] acc_s, acc_r;
   logic       prev_key, prev_stb, first_stb;
   logic [1:0] last_nz;
   int         gap, diff_cnt = 0;

   always @(negedge clk) begin
      logic key_now, tr_s, tr_r;
      vec_t e;
      key_now = s_m[10] ^ s_m[8];
      if (!rst_n) begin
         exp_q.delete();
         exp_q.push_back('{1'b0, 4'h0, I_CG, 4'd1});   // R1 reset idle group
         prev_s = 2'b00; prev_r = 2'b00;
         acc_s = '0; acc_r = '0;
         prev_stb = 1'b0; first_stb = 1'b1; gap = 0;
         last_nz = 2'b11;
      end else begin
         tr_s = (lvl_s != prev_s);
         tr_r = (lvl_r != prev_r);
         acc_s = {acc_s[3:0], tr_s ^ prev_key};
         acc_r = {acc_r[3:0], tr_r};
         if (lvl_s != lvl_r) diff_cnt++;
         // R7 level sequence
         if (tr_s) begin
            if (prev_s == 2'b00) begin
               check(lvl_s == ((last_nz == 2'b11) ? 2'b01 : 2'b11), "R7 step from zero",
                     lvl_s, (last_nz == 2'b11) ? 2'b01 : 2'b11);
               last_nz = lvl_s;
            end else begin
               check(lvl_s == 2'b00, "R7 return to zero", lvl_s, 0);
            end
         end
         // R8 strobe spacing
         gap++;
         if (stb_s) begin
            check(gap == (first_stb ? 4 : 5), "R8 strobe spacing", gap, first_stb ? 4 : 5);
            check(stb_r == stb_s, "R8 strobe match", stb_r, stb_s);
            gap = 0;
            first_stb = 1'b0;
         end
         if (prev_stb) begin
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               check(acc_r == e.cg, $sformatf("R%0d code group", e.tag), acc_r, e.cg);
               check(acc_s == e.cg, "R6 descrambled group", acc_s, e.cg);
            end else begin
               check(1'b0, "R8 group without stimulus", acc_r, 0);
            end
         end
         prev_stb = stb_s;
         prev_s = lvl_s;
         prev_r = lvl_r;
      end
      prev_key = key_now;
   end

   task automatic nib(input vec_t v);
      do @(negedge clk); while (!stb_s);
      #1;
      tx_en = v.en;
      txd   = v.nib;
      exp_q.push_back(v);
   endtask

   task automatic do_reset();
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      tx_en = 1'b0;
      repeat (3) @(negedge clk);
      check(lvl_s == 2'b00 && lvl_r == 2'b00, "R1 level in reset", lvl_s, 0);
      check(stb_s == 1'b0, "R1 strobe in reset", stb_s, 0);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      check(lvl_s == 2'b00 && lvl_r == 2'b00, "R1 level in reset", lvl_s, 0);
      check(stb_s == 1'b0, "R1 strobe in reset", stb_s, 0);
      #1;
      rst_n = 1'b1;
      repeat (3) nib('{1'b0, 4'h0, I_CG, 4'd5});   // R5
      for (int i = 0; i < NV; i++) nib(VECS[i]);

      // R1: reset in the middle of a payload restarts framing
      nib(VECS[1]);
      nib(VECS[2]);
      nib(VECS[10]);
      nib(VECS[11]);
      do_reset();
      nib('{1'b0, 4'h0, I_CG, 4'd1});
      nib('{1'b1, 4'h9, J_CG, 4'd1});
      nib('{1'b1, 4'h9, K_CG, 4'd2});
      nib('{1'b1, 4'h9, 5'b10011, 4'd4});
      nib('{1'b0, 4'h0, T_CG, 4'd3});
      nib('{1'b0, 4'h0, R_CG, 4'd3});
      repeat (3) nib('{1'b0, 4'h0, I_CG, 4'd5});

      // R6: scrambled line must differ from the plain one
      check(diff_cnt > 0, "R6 scrambling applied", diff_cnt, 1);
      finish_run();
   end

endmodule